// File: doc/BRIEF.md
# Sampled Interrupt Request Controller

This block gathers six interrupt request lines and hands one winner to the CPU's interrupt cycle. A request is first caught in a sticky input latch. A free-running sample strobe fires once every `SAMPLE_DIV` clocks, one machine cycle, and moves the caught requests into a pending register. Only the pending register reaches the mask and the priority picker, so a request is never seen internally before the next strobe.

Software reaches the block over a small register bus. It can write a priority select, a mask with a global enable, and the pending bits. The pending bits can be read and overwritten directly. The interrupt output stays low after reset until the three registers have been written in the order priority, mask, pending. When the CPU acknowledges, only the pending bit of the current winner is cleared.

Top module: `irq_sample_ctrl`

## Requirements
- R1: After reset the priority, mask and pending registers read as zero, and `irq_out` and `win_valid` are low.
- R2: A request input that is high at a clock edge is held in its latch until the next sample strobe. The strobe fires every `SAMPLE_DIV` (3) clocks. A pending bit is never set in the cycle the request is first caught, and it appears 1 to 3 cycles after that edge.
- R3: Register address 2 holds the pending bits in bits [5:0], with bits [7:6] reading 0. A write replaces all six bits, and that write takes precedence over any strobe set or acknowledge clear in the same cycle.
- R4: `win_valid` is high exactly when some bit of (pending AND mask[5:0]) is set. `win_idx` is the first such source in the circular order sel, sel+1, …, 5, 0, …, sel-1, where sel is the priority select.
- R5: Priority select values 6 and 7 behave as select 0.
- R6: `irq_out` = mask bit 7 (global enable) AND initialization complete AND `win_valid`.
- R7: Initialization completes once writes to address 0, then address 1, then address 2 occur in that order. A write that breaks the order restarts tracking, and a new address-0 write restarts it at step one. Completion holds until reset.
- R8: An `ack` pulse while `irq_out` is high clears only the pending bit of the current `win_idx`. The other bits are unchanged.
- R9: An `ack` while `irq_out` is low leaves the pending register unchanged.
- R10: Address 0 holds the priority select in bits [2:0]. Address 1 holds the per-source enables in bits [5:0] and the global enable in bit 7. Address 3 and all unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_in | input | 6 | Interrupt request lines, one per source |
| ack | input | 1 | Interrupt acknowledge pulse from the CPU |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| irq_out | output | 1 | Interrupt request to the CPU |
| win_idx | output | 3 | Index of the winning source |
| win_valid | output | 1 | Some enabled source is pending |

## Verification
Several properties are checked on every cycle:
- the interrupt output is gated by the global enable, initialization completion and a valid winner;
- the reported winner is both pending and enabled;
- pending bits only rise on a strobe or a software write;
- an acknowledge removes at most one bit, and that bit is the winner's.

The exact circular priority order, the treatment of select values 6 and 7, the latency from a request pulse to its pending bit, and the ordering rules of the initialization sequence can only be shown by the bench scenarios. The bench covers them with a full sweep of mask against pending and with directed sequences.

// File: rtl/irq_sample_ctrl.sv
module irq_sample_ctrl #(
  parameter int NSRC       = 6,
  parameter int SAMPLE_DIV = 3,
  localparam int IW = $clog2(NSRC),
  localparam int CW = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_in,
  input  logic            ack,
  input  logic            wr_en,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  output logic [7:0]      rdata,
  output logic            irq_out,
  output logic [IW-1:0]   win_idx,
  output logic            win_valid
);
  logic [NSRC-1:0] lat_q, pend_q, mask_q, pend_d, pend_clr, act;
  logic [IW-1:0]   prio_q, rot;
  logic            gen_q, strobe, done, pend_wr;
  logic [1:0]      seq_q;
  logic [CW-1:0]   cnt_q;

  assign strobe  = (cnt_q == CW'(SAMPLE_DIV - 1));
  assign done    = (seq_q == 2'd3);
  assign pend_wr = wr_en && (addr == 2'd2);
  assign act     = pend_q & mask_q;
  assign rot     = (int'(prio_q) < NSRC) ? prio_q : '0;

  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    for (int r = NSRC - 1; r >= 0; r--) begin
      int k;
      k = int'(rot) + r;
      if (k >= NSRC) k = k - NSRC;
      if (act[k]) begin
        win_valid = 1'b1;
        win_idx   = IW'(k);
      end
    end
  end

  assign irq_out  = gen_q && done && win_valid;
  assign pend_clr = (ack && irq_out) ? (NSRC'(1) << win_idx) : '0;
  assign pend_d   = pend_wr ? wdata[NSRC-1:0]
                  : ((pend_q & ~pend_clr) | (strobe ? lat_q : '0));

  always_comb begin
    case (addr)
      2'd0:    rdata = 8'(prio_q);
      2'd1:    rdata = 8'(mask_q) | {gen_q, 7'b0};
      2'd2:    rdata = 8'(pend_q);
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lat_q  <= '0;
      pend_q <= '0;
      mask_q <= '0;
      gen_q  <= 1'b0;
      prio_q <= '0;
      seq_q  <= 2'd0;
    end else begin
      cnt_q  <= strobe ? '0 : cnt_q + 1'b1;
      lat_q  <= strobe ? req_in : (lat_q | req_in);
      pend_q <= pend_d;
      if (wr_en) begin
        case (addr)
          2'd0: begin
            prio_q <= wdata[IW-1:0];
            seq_q  <= done ? 2'd3 : 2'd1;
          end
          2'd1: begin
            mask_q <= wdata[NSRC-1:0];
            gen_q  <= wdata[7];
            seq_q  <= done ? 2'd3 : ((seq_q == 2'd1) ? 2'd2 : 2'd0);
          end
          2'd2: seq_q <= done ? 2'd3 : ((seq_q == 2'd2) ? 2'd3 : 2'd0);
          default: ;
        endcase
      end
    end
  end
endmodule

module irq_sample_ctrl_chk #(
  parameter int NSRC = 6,
  localparam int IW = $clog2(NSRC)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ack,
  input logic            irq_out,
  input logic            win_valid,
  input logic [IW-1:0]   win_idx,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] lat_q,
  input logic            gen_q,
  input logic            done,
  input logic            strobe,
  input logic            pend_wr
);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_valid && gen_q && done));

  p_winner_live_r4: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (pend_q[win_idx] && mask_q[win_idx]));

  p_rise_on_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_wr && !strobe) |=> ((pend_q & ~$past(pend_q)) == '0));

  p_ack_clears_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_out && !pend_wr && !(strobe && lat_q[win_idx]))
      |=> !pend_q[$past(win_idx)]);

  p_ack_single_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pend_wr) |=> ($countones($past(pend_q) & ~pend_q) <= 1));

  p_no_ack_no_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_out && !pend_wr) |=> (($past(pend_q) & ~pend_q) == '0));
endmodule

bind irq_sample_ctrl irq_sample_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .irq_out(irq_out),
  .win_valid(win_valid), .win_idx(win_idx), .pend_q(pend_q),
  .mask_q(mask_q), .lat_q(lat_q), .gen_q(gen_q), .done(done),
  .strobe(strobe), .pend_wr(pend_wr)
);

// File: tb/irq_sample_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_sample_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] req_in = '0;
  logic       ack = 1'b0, wr_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_out, win_valid;
  logic [2:0] win_idx;
  int checks = 0, errors = 0;

  irq_sample_ctrl dut_i (.clk(clk), .rst_n(rst_n), .req_in(req_in), .ack(ack),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .irq_out(irq_out), .win_idx(win_idx), .win_valid(win_valid));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a; #1; v = int'(rdata);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  function automatic int exp_win(input int sel, input int act);
    int s;
    s = (sel < 6) ? sel : 0;
    for (int r = 0; r < 6; r++)
      if (act[(s + r) % 6]) return (s + r) % 6;
    return -1;
  endfunction

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    do_reset();
    // R1 / R10 reset state and address 3
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk($sformatf("R1 reg%0d", a), v, 0);
    end
    chk("R1 irq_out", int'(irq_out), 0);
    chk("R1 win_valid", int'(win_valid), 0);

    // R10 field readback
    wr(2'd0, 8'hFD); rd(2'd0, v); chk("R10 prio field", v, 5);
    wr(2'd1, 8'hFF); rd(2'd1, v); chk("R10 mask field", v, 8'hBF);
    wr(2'd3, 8'hFF); rd(2'd3, v); chk("R10 addr3 reads 0", v, 0);
    wr(2'd2, 8'hFF); rd(2'd2, v); chk("R3 pend field", v, 8'h3F);

    // R7 out-of-order: mask, prio, pend does not complete
    do_reset();
    wr(2'd1, 8'hBF); wr(2'd0, 8'h00); wr(2'd2, 8'h01);
    chk("R7 out of order irq", int'(irq_out), 0);
    chk("R7 winner still valid", int'(win_valid), 1);
    wr(2'd0, 8'h00); wr(2'd2, 8'h01); wr(2'd1, 8'hBF);
    chk("R7 skipped step irq", int'(irq_out), 0);
    wr(2'd0, 8'h00); wr(2'd1, 8'hBF); wr(2'd2, 8'h01);
    chk("R7 in order irq", int'(irq_out), 1);
    wr(2'd2, 8'h01); wr(2'd1, 8'hBF);
    chk("R7 completion sticky", int'(irq_out), 1);

    // R4 / R5 / R6 sweep of mask against pending
    for (int m = 0; m < 64; m++)
      for (int p = 0; p < 64; p++) begin
        int sel, gen, e;
        sel = (m + p) & 7;
        gen = ((m ^ (p >> 5)) & 1);
        wr(2'd0, 8'(sel));
        wr(2'd1, 8'(m | (gen << 7)));
        wr(2'd2, 8'(p));
        e = exp_win(sel, m & p);
        chk($sformatf("R4 valid m%0d p%0d", m, p), int'(win_valid), (e >= 0) ? 1 : 0);
        if (e >= 0)
          chk($sformatf("%s idx m%0d p%0d sel%0d", (sel > 5) ? "R5" : "R4", m, p, sel),
              int'(win_idx), e);
        chk($sformatf("R6 irq m%0d p%0d", m, p), int'(irq_out), (e >= 0) ? gen : 0);
      end

    // R8 acknowledge walks the rotation from select 2
    wr(2'd0, 8'h02); wr(2'd1, 8'hBF); wr(2'd2, 8'h3F);
    begin
      int pend;
      pend = 8'h3F;
      for (int s = 0; s < 6; s++) begin
        int e;
        e = (2 + s) % 6;
        chk($sformatf("R8 winner step%0d", s), int'(win_idx), e);
        pulse_ack();
        pend = pend & ~(1 << e);
        rd(2'd2, v); chk($sformatf("R8 pend after ack%0d", s), v, pend);
      end
    end
    chk("R8 drained irq", int'(irq_out), 0);

    // R9 ack with global enable off
    wr(2'd1, 8'h3F); wr(2'd2, 8'h3F);
    pulse_ack();
    rd(2'd2, v); chk("R9 ack ignored", v, 8'h3F);
    chk("R9 irq low", int'(irq_out), 0);

    // R2 sampled capture of single-cycle pulses
    for (int i = 0; i < 6; i++) begin
      int lat;
      wr(2'd2, 8'h00);
      @(negedge clk); req_in = 6'(1 << i);
      @(negedge clk); req_in = '0;
      rd(2'd2, v); chk($sformatf("R2 src%0d not before strobe", i), v, 0);
      lat = 0;
      for (int c = 1; c <= 4 && lat == 0; c++) begin
        @(negedge clk); rd(2'd2, v);
        if (v != 0) lat = c;
      end
      chk($sformatf("R2 src%0d latency in 1..3", i), int'(lat >= 1 && lat <= 3), 1);
      chk($sformatf("R2 src%0d pend value", i), v, 1 << i);
      @(negedge clk); @(negedge clk); @(negedge clk);
      rd(2'd2, v); chk($sformatf("R2 src%0d latch released", i), v, 1 << i);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule